// File: doc/BRIEF.md
# Searchable Pipeline Queue

This block is a small in-order queue placed between the decode and execute stages of a pipelined processor. Each entry holds one decoded instruction template: an operation kind, a destination register name and two operand values. The decode side pushes templates, and the execute side reads the oldest template and then pops it. A taken branch can empty the whole queue in one cycle with a flush.

Alongside the queue operations, the block has two combinational search ports. Each port takes a register name and reports, in the same cycle, whether any entry still held in the queue will write that register. Only add and load templates write a register. Branch and store templates never produce a hit. The decoder uses the two ports to check both source registers of the next instruction, and stalls while either one hits.

Top module: `spq_queue`

## Requirements
- R1: After reset the queue is empty: `enq_ready` is 1, `head_valid` is 0 and both search hits are 0.
- R2: Templates leave in the order they were accepted. The head fields show the oldest held entry and stay stable until it is popped or flushed.
- R3: `enq_ready` is 0 exactly when DEPTH entries are held. A push offered while the queue is full is dropped and leaves the contents unchanged.
- R4: A pop requested while the queue is empty has no effect. The next accepted push becomes the head.
- R5: `flush` empties the queue by the next cycle. When a push and a flush are offered in the same cycle, the flush wins and the queue is left empty.
- R6: A search port hits when a held entry has op code 0 (add) or 2 (load) and its destination equals the queried name. `enq_op` and `head_op` are 2-bit fields.
- R7: Entries with op code 1 (branch if zero) or 3 (store) never make a search port hit, whatever their destination field holds.
- R8: The two search ports are independent. Each answers its own query in the same cycle.
- R9: An entry that has been popped or flushed no longer contributes to any search result.
- R10: A push and a pop in the same cycle at partial occupancy keep the count unchanged. The pushed entry lines up behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Push request |
| enq_ready | output | 1 | Queue can accept a push |
| enq_op | input | 2 | Op code of the pushed template |
| enq_dst | input | REG_W | Destination register of the pushed template |
| enq_opa | input | VAL_W | First operand value |
| enq_opb | input | VAL_W | Second operand value |
| deq_req | input | 1 | Pop the head entry |
| flush | input | 1 | Empty the queue |
| head_valid | output | 1 | Head entry present |
| head_op | output | 2 | Op code of the head entry |
| head_dst | output | REG_W | Destination register of the head entry |
| head_opa | output | VAL_W | First operand value of the head entry |
| head_opb | output | VAL_W | Second operand value of the head entry |
| srch0_reg | input | REG_W | Register name queried on search port 0 |
| srch0_hit | output | 1 | Port 0 found a pending writer |
| srch1_reg | input | REG_W | Register name queried on search port 1 |
| srch1_hit | output | 1 | Port 1 found a pending writer |

## Verification
The checker keeps an occupancy count built from the port handshakes. On every cycle it checks that the ready and valid flags agree with that count. It also checks that a flush leaves the queue empty, that an empty queue never produces a search hit, and that the head holds steady while it is not popped. The bench scenarios cover the rest. They show the exact match rules for each op code, both ports working at once, lost entries after pops and flushes, a dropped push while full, and data order across pointer wraparound.

// File: rtl/spq_pkg.sv
package spq_pkg;

    localparam int REG_W = 5;
    localparam int VAL_W = 32;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_BRZ   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STORE = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] dst;
        logic [VAL_W-1:0] opa;
        logic [VAL_W-1:0] opb;
    } tmpl_t;

    function automatic logic writes_reg(input op_e op);
        return (op == OP_ADD) || (op == OP_LOAD);
    endfunction

endpackage

// File: rtl/spq_store.sv
module spq_store
    import spq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  tmpl_t                wr_data,
    input  logic                 rd_en,
    input  logic                 clr,
    output tmpl_t                head_data,
    output logic                 full,
    output logic                 empty,
    output tmpl_t [DEPTH-1:0]    slots,
    output logic  [DEPTH-1:0]    live
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    tmpl_t [DEPTH-1:0] mem;
    logic [PTR_W-1:0]  head_ptr, tail_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (wr_en) tail_ptr <= bump(tail_ptr);
            if (rd_en) head_ptr <= bump(head_ptr);
            if (wr_en && !rd_en)      count <= count + 1'b1;
            else if (rd_en && !wr_en) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) mem[tail_ptr] <= wr_data;
    end

    // Entry i is live when its distance from the head is below the count.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int off;
            off = (i >= int'(head_ptr)) ? i - int'(head_ptr)
                                        : i + DEPTH - int'(head_ptr);
            live[i] = (off < int'(count));
        end
    end

    assign slots     = mem;
    assign head_data = mem[head_ptr];
    assign full      = (int'(count) == DEPTH);
    assign empty     = (count == '0);

endmodule

// File: rtl/spq_match.sv
module spq_match
    import spq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  tmpl_t [DEPTH-1:0] slots,
    input  logic  [DEPTH-1:0] live,
    input  logic  [REG_W-1:0] query,
    output logic              hit
);
    logic [DEPTH-1:0] per_slot;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign per_slot[g] = live[g] && writes_reg(slots[g].op)
                             && (slots[g].dst == query);
    end

    assign hit = |per_slot;

endmodule

// File: rtl/spq_queue.sv
module spq_queue
    import spq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    output logic             enq_ready,
    input  logic [1:0]       enq_op,
    input  logic [REG_W-1:0] enq_dst,
    input  logic [VAL_W-1:0] enq_opa,
    input  logic [VAL_W-1:0] enq_opb,
    input  logic             deq_req,
    input  logic             flush,
    output logic             head_valid,
    output logic [1:0]       head_op,
    output logic [REG_W-1:0] head_dst,
    output logic [VAL_W-1:0] head_opa,
    output logic [VAL_W-1:0] head_opb,
    input  logic [REG_W-1:0] srch0_reg,
    output logic             srch0_hit,
    input  logic [REG_W-1:0] srch1_reg,
    output logic             srch1_hit
);
    localparam int NPORT = 2;

    tmpl_t             in_t, hd_t;
    tmpl_t [DEPTH-1:0] slots;
    logic  [DEPTH-1:0] live;
    logic              full, empty, do_wr, do_rd;
    logic [REG_W-1:0]  qry  [NPORT];
    logic [NPORT-1:0]  hits;

    assign in_t.op  = op_e'(enq_op);
    assign in_t.dst = enq_dst;
    assign in_t.opa = enq_opa;
    assign in_t.opb = enq_opb;

    // Flush has priority over both push and pop.
    assign do_wr = enq_valid && !full && !flush;
    assign do_rd = deq_req && !empty && !flush;

    spq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (do_wr),
        .wr_data   (in_t),
        .rd_en     (do_rd),
        .clr       (flush),
        .head_data (hd_t),
        .full      (full),
        .empty     (empty),
        .slots     (slots),
        .live      (live)
    );

    assign qry[0] = srch0_reg;
    assign qry[1] = srch1_reg;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        spq_match #(.DEPTH(DEPTH)) u_match (
            .slots (slots),
            .live  (live),
            .query (qry[p]),
            .hit   (hits[p])
        );
    end

    assign srch0_hit  = hits[0];
    assign srch1_hit  = hits[1];
    assign enq_ready  = !full;
    assign head_valid = !empty;
    assign head_op    = hd_t.op;
    assign head_dst   = hd_t.dst;
    assign head_opa   = hd_t.opa;
    assign head_opb   = hd_t.opb;

endmodule

// File: rtl/spq_queue_chk.sv
module spq_queue_chk
    import spq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_valid,
    input logic             enq_ready,
    input logic             deq_req,
    input logic             flush,
    input logic             head_valid,
    input logic [1:0]       head_op,
    input logic [REG_W-1:0] head_dst,
    input logic             srch0_hit,
    input logic             srch1_hit
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    logic [CNT_W-1:0] occ;
    logic acc_e, acc_d;

    assign acc_e = enq_valid && enq_ready && !flush;
    assign acc_d = deq_req && head_valid && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush)           occ <= '0;
        else if (acc_e && !acc_d)   occ <= occ + 1'b1;
        else if (acc_d && !acc_e)   occ <= occ - 1'b1;
    end

    // R3
    ready_vs_occ_chk: assert property (@(posedge clk) disable iff (rst)
        enq_ready == (int'(occ) < DEPTH));

    // R4
    valid_vs_occ_chk: assert property (@(posedge clk) disable iff (rst)
        head_valid == (occ != '0));

    // R5
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!head_valid && enq_ready));

    // R9
    empty_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !head_valid |-> (!srch0_hit && !srch1_hit));

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !deq_req && !flush) |=>
        (head_valid && $stable(head_op) && $stable(head_dst)));

endmodule

bind spq_queue spq_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enq_valid  (enq_valid),
    .enq_ready  (enq_ready),
    .deq_req    (deq_req),
    .flush      (flush),
    .head_valid (head_valid),
    .head_op    (head_op),
    .head_dst   (head_dst),
    .srch0_hit  (srch0_hit),
    .srch1_hit  (srch1_hit)
);

// File: tb/test_spq_queue.sv
module test_spq_queue;
    import spq_pkg::*;

    localparam int DEPTH = 2;
    localparam int TW = 2 + REG_W + 2 * VAL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enq_valid = 1'b0, deq_req = 1'b0, flush = 1'b0;
    logic [1:0] enq_op = '0;
    logic [REG_W-1:0] enq_dst = '0, srch0_reg = '0, srch1_reg = '0;
    logic [VAL_W-1:0] enq_opa = '0, enq_opb = '0;
    logic enq_ready, head_valid, srch0_hit, srch1_hit;
    logic [1:0] head_op;
    logic [REG_W-1:0] head_dst;
    logic [VAL_W-1:0] head_opa, head_opb;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [TW-1:0] exp_q[$];

    always #2 clk = ~clk;

    spq_queue #(.DEPTH(DEPTH)) i_spq_queue (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_op(enq_op), .enq_dst(enq_dst), .enq_opa(enq_opa), .enq_opb(enq_opb),
        .deq_req(deq_req), .flush(flush),
        .head_valid(head_valid), .head_op(head_op), .head_dst(head_dst),
        .head_opa(head_opa), .head_opb(head_opb),
        .srch0_reg(srch0_reg), .srch0_hit(srch0_hit),
        .srch1_reg(srch1_reg), .srch1_hit(srch1_hit)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; the scoreboard follows the requirements.
    task automatic step(input bit ev, input logic [1:0] op, input int dst,
                        input int a, input int b, input bit dq, input bit fl);
        bit acc;
        bit pop;
        @(negedge clk);
        enq_valid = ev; enq_op = op; enq_dst = REG_W'(dst);
        enq_opa = VAL_W'(a); enq_opb = VAL_W'(b);
        deq_req = dq; flush = fl;
        acc = ev && (exp_q.size() < DEPTH) && !fl;
        pop = dq && (exp_q.size() > 0) && !fl;
        @(posedge clk);
        if (fl) exp_q.delete();
        else begin
            if (pop) void'(exp_q.pop_front());
            if (acc) exp_q.push_back({op, REG_W'(dst), VAL_W'(a), VAL_W'(b)});
        end
        #1;
        enq_valid = 0; deq_req = 0; flush = 0;
    endtask

    // Monitor: compare the head against the oldest expected item.
    task automatic mon(input string tag);
        logic [TW-1:0] e;
        #1;
        chk(head_valid == (exp_q.size() > 0), {tag, " head_valid"}, head_valid, exp_q.size() > 0);
        chk(enq_ready == (exp_q.size() < DEPTH), {tag, " enq_ready"}, enq_ready, exp_q.size() < DEPTH);
        if (exp_q.size() > 0) begin
            e = exp_q[0];
            chk({head_op, head_dst, head_opa, head_opb} == e, {tag, " head"},
                longint'({head_dst, head_opa}), longint'(e[TW-3 -: REG_W+VAL_W]));
        end
    endtask

    function automatic bit model_hit(input int r);
        foreach (exp_q[i]) begin
            logic [1:0] o;
            o = exp_q[i][TW-1 -: 2];
            if ((o == 2'd0 || o == 2'd2) && exp_q[i][TW-3 -: REG_W] == REG_W'(r)) return 1;
        end
        return 0;
    endfunction

    task automatic find2(input int r0, input int r1, input string tag);
        srch0_reg = REG_W'(r0); srch1_reg = REG_W'(r1);
        #1;
        chk(srch0_hit == model_hit(r0), {tag, " port0"}, srch0_hit, model_hit(r0));
        chk(srch1_hit == model_hit(r1), {tag, " port1"}, srch1_hit, model_hit(r1));
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        mon("R1"); find2(0, 5, "R1");
        // R2 R6 R8: add to r5, load to r7
        step(1, 2'd0, 5, 32'h11, 32'h22, 0, 0); mon("R2");
        find2(5, 7, "R6 R8");
        step(1, 2'd2, 7, 32'h33, 32'h44, 0, 0); mon("R3 full");
        find2(5, 7, "R8 both");
        // R3 push while full is dropped
        step(1, 2'd0, 9, 32'h55, 32'h66, 0, 0); mon("R3 drop");
        find2(9, 7, "R3 no r9");
        step(0, 0, 0, 0, 0, 1, 0); mon("R2 pop1");
        find2(5, 7, "R9 popped");
        step(0, 0, 0, 0, 0, 1, 0); mon("R2 pop2");
        // R4 pop on empty ignored
        step(0, 0, 0, 0, 0, 1, 0); mon("R4 empty pop");
        step(1, 2'd3, 3, 32'h77, 32'h88, 0, 0); mon("R4 next head");
        step(1, 2'd1, 4, 32'h0, 32'h99, 0, 0); mon("R7 full");
        find2(3, 4, "R7 no hit");
        // R5 flush, then flush with push
        step(0, 0, 0, 0, 0, 0, 1); mon("R5 flush");
        step(1, 2'd0, 6, 32'h1, 32'h2, 0, 0);
        step(1, 2'd0, 8, 32'h3, 32'h4, 0, 1); mon("R5 flush wins");
        find2(6, 8, "R9 flushed");
        // R10 push and pop together at occupancy 1
        step(1, 2'd0, 11, 32'ha, 32'hb, 0, 0);
        step(1, 2'd2, 12, 32'hc, 32'hd, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0); find2(11, 12, "R9 after pop");
        step(1, 2'd0, 13, 32'he, 32'hf, 1, 0); mon("R10");
        find2(12, 13, "R10 find");
        // R2 order across wraparound
        for (int k = 0; k < 12; k++) begin
            step(1, 2'(k), k + 1, k * 3, k * 7, (k % 3) != 0, 0);
            mon("R2 wrap");
            find2(k + 1, k, "R6 wrap");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule